// File: doc/BRIEF.md
# DDR SDRAM Low-Power State Sequencer

This block owns the low-power states of one DDR SDRAM command path. It puts the memory into self-refresh when two control inputs are both set. When both are cleared it raises CKE, counts out two recovery windows and issues the fixed wake-up sequence: an all-bank refresh, a dummy read, a precharge of all banks, and a second all-bank refresh. The second refresh is what starts the controller's delay-adjustment logic. Only after that does the periodic refresh timer start again and access get granted.

Between accesses the block can also drop CKE by itself. When automatic power-down is enabled, CKE goes low once an access ends and comes back high one cycle before the next access is granted. Each transition costs one memory clock. Requesters use a simple request/grant/done handshake. The read and non-read exit windows are derived from parameters: the non-read window is a nanosecond figure divided by the clock period and rounded up.

Top module: `sdr_lowpower_seq`

## Requirements
- R1: During reset and right after it, CKE is high, cmdValid and accGrant are low, the self-refresh flag is low and cmdCode is 0.
- R2: From the powered-up idle state, with slfRefReq and refOnReq both high, a single-cycle self-refresh-entry command (code 4) is issued with CKE still high. In the next cycle CKE is low and srefActive is high. While exactly one of the two controls is high, the block stays in self-refresh.
- R3: The cycle after both controls are seen low in self-refresh, CKE is high and srefActive is low. CKE then stays high through the whole recovery.
- R4: The first recovery command is an all-bank refresh (code 1). It appears exactly NR cycles after the CKE-rise cycle, where NR = ceil(EXIT_NS*1000/CLK_PS), and no command appears before it.
- R5: The dummy read (code 3) appears max(READ_WAIT_CYC, NR+1) cycles after the CKE-rise cycle, never earlier.
- R6: The cycle after the read carries precharge-all (code 2), and the cycle after that carries the second all-bank refresh (code 1).
- R7: accGrant stays low from self-refresh entry through the second recovery refresh. A request held across recovery is granted in the cycle right after that refresh.
- R8: With power-down disabled and no access, periodic refreshes are exactly refInterval+1 cycles apart (refInterval >= 2). The first one follows the second recovery refresh by the same distance.
- R9: With automatic power-down enabled, CKE is low the cycle after accDone ends an access, and it stays low while the block is idle.
- R10: A request made during power-down raises CKE the next cycle with no grant yet. The grant follows one cycle later, provided no refresh is due.
- R11: With power-down disabled, CKE stays high outside self-refresh, and a request from idle is granted the following cycle.
- R12: cmdValid is high exactly when cmdCode is nonzero. The codes are 0 no-op, 1 all-bank refresh, 2 precharge-all, 3 read, 4 self-refresh entry.
- R13: A refresh falling due during power-down raises CKE for one cycle before the refresh is issued, so periodic refreshes are refInterval+2 cycles apart in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rstN | input | 1 | Active-low synchronous reset |
| slfRefReq | input | 1 | Self-refresh request control |
| refOnReq | input | 1 | Refresh-enable control; with slfRefReq it selects entry (both set) or exit (both clear) |
| autoPdEn | input | 1 | Enables automatic CKE power-down between accesses |
| accReq | input | 1 | Access request, held until granted |
| accDone | input | 1 | One-cycle pulse ending the granted access |
| refInterval | input | RI_W | Periodic refresh spacing in cycles |
| cmdCode | output | 3 | Command code for the current cycle |
| cmdValid | output | 1 | High in cycles carrying a command |
| cke | output | 1 | Clock-enable level to the memory |
| srefActive | output | 1 | High while the memory sits in self-refresh |
| accGrant | output | 1 | High while an access may proceed |

## Verification
The hardest situation to reach from the ports is the recovery ordering when the read window and the non-read window end close together. It is equally hard to reach the point where a held request collides with the last recovery command. The bench leaves self-refresh after several dwell lengths, alternating which single control stays high, and then compares every cycle from the CKE rise against offsets computed from NR and the read window. Half of the runs keep a request pending throughout, which pins the grant to the cycle after the second refresh. The other half leave the bus idle, so the first periodic refresh offset is checked directly.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_REFA   = 3'd1,
    CMD_PREALL = 3'd2,
    CMD_READ   = 3'd3,
    CMD_SRE    = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACC,
    S_PDN,
    S_PUP,
    S_AREF,
    S_SRE,
    S_SREF,
    S_XWAIT,
    S_XREF1,
    S_XWRD,
    S_XRD,
    S_XPRE,
    S_XREF2
  } state_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic exitClr;
    logic exitRun;
    logic refClr;
  } tmr_strb_t;

endpackage

// File: rtl/lps_timers.sv
module lps_timers
  import lps_pkg::*;
#(
  parameter int NR_CYC = 33,
  parameter int RD_CYC = 200,
  parameter int RI_W   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  tmr_strb_t       strb,
  input  logic [RI_W-1:0] refInterval,
  output logic            nrOpenNext,
  output logic            rdOpenNext,
  output logic            refDue
);

  localparam int XW = $clog2(NR_CYC + RD_CYC + 2);
  localparam logic [XW-1:0] XMAX  = '1;
  localparam logic [XW-1:0] NR_M1 = XW'(NR_CYC - 1);
  localparam logic [XW-1:0] RD_M1 = XW'(RD_CYC - 1);
  localparam logic [RI_W-1:0] RMAX = '1;

  logic [XW-1:0]   exitCnt;
  logic [RI_W-1:0] refCnt;
  logic [RI_W-1:0] refLimit;

  // cycles elapsed since CKE rose on self-refresh exit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exitCnt <= '0;
    end else if (strb.exitClr) begin
      exitCnt <= '0;
    end else if (strb.exitRun && exitCnt != XMAX) begin
      exitCnt <= exitCnt + 1'b1;
    end
  end

  // cycles elapsed since the last all-bank refresh
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (strb.refClr) begin
      refCnt <= '0;
    end else if (refCnt != RMAX) begin
      refCnt <= refCnt + 1'b1;
    end
  end

  assign refLimit   = refInterval - RI_W'(1);
  // flags say whether the following cycle lies inside the allowed window
  assign nrOpenNext = exitCnt >= NR_M1;
  assign rdOpenNext = exitCnt >= RD_M1;
  assign refDue     = refCnt >= refLimit;

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slfRefReq,
  input  logic       refOnReq,
  input  logic       autoPdEn,
  input  logic       accReq,
  input  logic       accDone,
  input  logic       nrOpenNext,
  input  logic       rdOpenNext,
  input  logic       refDue,
  output tmr_strb_t  strb,
  output logic [2:0] cmdCode,
  output logic       cmdValid,
  output logic       cke,
  output logic       srefActive,
  output logic       accGrant
);

  state_e state, nxt;
  cmd_e   cmdSel;
  logic   sEnter, sExit, inRecov, refHold;

  assign sEnter = slfRefReq && refOnReq;
  assign sExit  = !slfRefReq && !refOnReq;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: begin
        if (sEnter)        nxt = S_SRE;
        else if (refDue)   nxt = S_AREF;
        else if (accReq)   nxt = S_ACC;
        else if (autoPdEn) nxt = S_PDN;
      end
      S_ACC:   if (accDone) nxt = autoPdEn ? S_PDN : S_IDLE;
      S_PDN:   if (!autoPdEn || sEnter || refDue || accReq) nxt = S_PUP;
      S_PUP: begin
        if (refDue)      nxt = S_AREF;
        else if (accReq) nxt = S_ACC;
        else             nxt = S_IDLE;
      end
      S_AREF:  nxt = S_IDLE;
      S_SRE:   nxt = S_SREF;
      S_SREF:  if (sExit) nxt = S_XWAIT;
      S_XWAIT: if (nrOpenNext) nxt = S_XREF1;
      S_XREF1: nxt = rdOpenNext ? S_XRD : S_XWRD;
      S_XWRD:  if (rdOpenNext) nxt = S_XRD;
      S_XRD:   nxt = S_XPRE;
      S_XPRE:  nxt = S_XREF2;
      S_XREF2: nxt = accReq ? S_ACC : S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  // command selection per state
  always_comb begin
    case (state)
      S_AREF, S_XREF1, S_XREF2: cmdSel = CMD_REFA;
      S_XRD:                    cmdSel = CMD_READ;
      S_XPRE:                   cmdSel = CMD_PREALL;
      S_SRE:                    cmdSel = CMD_SRE;
      default:                  cmdSel = CMD_NOP;
    endcase
  end

  assign inRecov  = state inside {S_XWAIT, S_XREF1, S_XWRD, S_XRD, S_XPRE, S_XREF2};
  assign refHold  = inRecov || (state inside {S_AREF, S_SRE, S_SREF});

  assign strb.exitClr = !inRecov;
  assign strb.exitRun = inRecov;
  assign strb.refClr  = refHold;

  assign cmdCode    = cmdSel;
  assign cmdValid   = state inside {S_AREF, S_SRE, S_XREF1, S_XRD, S_XPRE, S_XREF2};
  assign cke        = !(state inside {S_SREF, S_PDN});
  assign srefActive = (state == S_SREF);
  assign accGrant   = (state == S_ACC);

endmodule

// File: rtl/sdr_lowpower_seq.sv
module sdr_lowpower_seq
  import lps_pkg::*;
#(
  parameter int CLK_PS        = 4000,
  parameter int EXIT_NS       = 130,
  parameter int READ_WAIT_CYC = 200,
  parameter int RI_W          = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slfRefReq,
  input  logic            refOnReq,
  input  logic            autoPdEn,
  input  logic            accReq,
  input  logic            accDone,
  input  logic [RI_W-1:0] refInterval,
  output logic [2:0]      cmdCode,
  output logic            cmdValid,
  output logic            cke,
  output logic            srefActive,
  output logic            accGrant
);

  // non-read exit window in cycles, rounded up, at least one
  localparam int NR_RAW = (EXIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int NR_CYC = (NR_RAW < 1) ? 1 : NR_RAW;
  localparam int RD_CYC = (READ_WAIT_CYC < 1) ? 1 : READ_WAIT_CYC;

  tmr_strb_t strb;
  logic      nrOpenNext, rdOpenNext, refDue;

  lps_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .slfRefReq  (slfRefReq),
    .refOnReq   (refOnReq),
    .autoPdEn   (autoPdEn),
    .accReq     (accReq),
    .accDone    (accDone),
    .nrOpenNext (nrOpenNext),
    .rdOpenNext (rdOpenNext),
    .refDue     (refDue),
    .strb       (strb),
    .cmdCode    (cmdCode),
    .cmdValid   (cmdValid),
    .cke        (cke),
    .srefActive (srefActive),
    .accGrant   (accGrant)
  );

  lps_timers #(
    .NR_CYC (NR_CYC),
    .RD_CYC (RD_CYC),
    .RI_W   (RI_W)
  ) tmr_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .refInterval (refInterval),
    .nrOpenNext  (nrOpenNext),
    .rdOpenNext  (rdOpenNext),
    .refDue      (refDue)
  );

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int CLK_PS        = 4000,
  parameter int EXIT_NS       = 130,
  parameter int READ_WAIT_CYC = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       autoPdEn,
  input logic       accDone,
  input logic [2:0] cmdCode,
  input logic       cmdValid,
  input logic       cke,
  input logic       srefActive,
  input logic       accGrant
);

  localparam int NR_RAW = (EXIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int unsigned NR_LIM = (NR_RAW < 1) ? 1 : NR_RAW;
  localparam int unsigned RD_LIM = (READ_WAIT_CYC < 1) ? 1 : READ_WAIT_CYC;
  localparam int unsigned SAT    = 32'h0000_FFFF;

  // independent count of cycles since CKE came back from self-refresh
  int unsigned sinceRise;
  always_ff @(posedge clk) begin
    if (!rstN)                 sinceRise <= SAT;
    else if (srefActive)       sinceRise <= 0;
    else if (sinceRise != SAT) sinceRise <= sinceRise + 1;
  end

  p_cmd_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid == (cmdCode != 3'd0));

  p_sref_cke_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    srefActive |-> !cke);

  p_enter_then_sref_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd4) |=> srefActive);

  p_exit_cke_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srefActive) |-> cke);

  p_nonread_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (sinceRise >= NR_LIM));

  p_read_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd3) |-> (sinceRise >= RD_LIM));

  p_pre_after_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd3) |=> (cmdValid && cmdCode == 3'd2));

  p_refa_after_pre_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd2) |=> (cmdValid && cmdCode == 3'd1));

  p_no_grant_sref_r7: assert property (@(posedge clk) disable iff (!rstN)
    srefActive |-> !accGrant);

  p_grant_after_cke_r10: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (cke && $past(cke)));

  p_pd_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accGrant && accDone && autoPdEn) |=> !cke);

endmodule

bind sdr_lowpower_seq lps_checker #(
  .CLK_PS        (CLK_PS),
  .EXIT_NS       (EXIT_NS),
  .READ_WAIT_CYC (READ_WAIT_CYC)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .autoPdEn   (autoPdEn),
  .accDone    (accDone),
  .cmdCode    (cmdCode),
  .cmdValid   (cmdValid),
  .cke        (cke),
  .srefActive (srefActive),
  .accGrant   (accGrant)
);

// File: tb/sdr_lowpower_seq_tb.sv
`timescale 1ns/1ps
module sdr_lowpower_seq_tb_top;

  localparam int CLK_PS  = 4000;
  localparam int EXIT_NS = 130;
  localparam int RD_WAIT = 200;
  localparam int EXP_NR  = (EXIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_RD  = (RD_WAIT > EXP_NR + 1) ? RD_WAIT : EXP_NR + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slfRefReq = 1'b0, refOnReq = 1'b0, autoPdEn = 1'b0;
  logic        accReq = 1'b0, accDone = 1'b0;
  logic [15:0] refInterval = 16'd60000;
  logic [2:0]  cmdCode;
  logic        cmdValid, cke, srefActive, accGrant;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdr_lowpower_seq #(
    .CLK_PS (CLK_PS), .EXIT_NS (EXIT_NS), .READ_WAIT_CYC (RD_WAIT), .RI_W (16)
  ) dut_i (
    .clk (clk), .rstN (rstN), .slfRefReq (slfRefReq), .refOnReq (refOnReq),
    .autoPdEn (autoPdEn), .accReq (accReq), .accDone (accDone),
    .refInterval (refInterval), .cmdCode (cmdCode), .cmdValid (cmdValid),
    .cke (cke), .srefActive (srefActive), .accGrant (accGrant)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chkIdleState(input string tag);
    chkEq(tag, int'(cke), 1);
    chkEq(tag, int'(cmdValid), 0);
    chkEq(tag, int'(cmdCode), 0);
    chkEq(tag, int'(accGrant), 0);
    chkEq(tag, int'(srefActive), 0);
  endtask

  // self-refresh entry, dwell with mixed controls, exit and recovery
  task automatic runRecovery(input int dwell, input bit holdReq, input int ri);
    int eR2, last, expCmd, expGnt;
    string tag;
    autoPdEn = 1'b0; accReq = 1'b0; refInterval = 16'd60000;
    step(5);
    slfRefReq = 1'b1; refOnReq = 1'b1;
    step(1);
    chkEq("R2 entry command", int'(cmdValid ? cmdCode : 3'd0), 4);
    chkEq("R2 cke during entry", int'(cke), 1);
    step(1);
    chkEq("R2 sref flag", int'(srefActive), 1);
    chkEq("R2 cke low", int'(cke), 0);
    refInterval = 16'(ri);
    accReq = holdReq;
    for (int d = 0; d < dwell; d++) begin
      slfRefReq = d[0]; refOnReq = !d[0];
      step(1);
      chkEq("R2 mixed controls hold sref", int'(srefActive), 1);
      chkEq("R7 no grant in sref", int'(accGrant), 0);
    end
    slfRefReq = 1'b0; refOnReq = 1'b0;
    step(1);
    chkEq("R3 cke up on exit", int'(cke), 1);
    chkEq("R3 sref flag clear", int'(srefActive), 0);
    eR2  = EXP_RD + 2;
    last = holdReq ? eR2 + 2 : eR2 + ri + 1;
    for (int o = 0; o <= last; o++) begin
      if (o > 0) step(1);
      expCmd = 0; tag = "R4 quiet window";
      if (o == EXP_NR)                   begin expCmd = 1; tag = "R4 first refresh"; end
      else if (o == EXP_RD)              begin expCmd = 3; tag = "R5 dummy read"; end
      else if (o == EXP_RD + 1)          begin expCmd = 2; tag = "R6 precharge-all"; end
      else if (o == eR2)                 begin expCmd = 1; tag = "R6 second refresh"; end
      else if (!holdReq && o == eR2 + ri + 1) begin expCmd = 1; tag = "R8 first periodic refresh"; end
      chkEq(tag, int'(cmdValid ? cmdCode : 3'd7), expCmd == 0 ? 7 : expCmd);
      chkEq("R12 strobe matches code", int'(cmdValid), int'(cmdCode != 3'd0));
      chkEq("R3 cke high in recovery", int'(cke), 1);
      expGnt = (holdReq && o == eR2 + 1) ? 1 : 0;
      chkEq("R7 grant timing", int'(accGrant), expGnt);
      if (holdReq && o == eR2 + 1) begin accReq = 1'b0; accDone = 1'b1; end
      if (o == eR2 + 2) accDone = 1'b0;
    end
    accReq = 1'b0; accDone = 1'b0;
  endtask

  // periodic refresh spacing, with or without power-down
  task automatic runPeriodic(input bit pd, input int ri);
    int cmdA[64];
    bit ckeA[64];
    int pos[16];
    int n, w;
    autoPdEn = pd; accReq = 1'b0; refInterval = 16'(ri);
    step(2 * (ri + 3) + 5);
    w = 3 * (ri + 2) + 2;
    for (int t = 0; t < w; t++) begin
      step(1);
      cmdA[t] = cmdValid ? int'(cmdCode) : 0;
      ckeA[t] = cke;
    end
    n = 0;
    for (int t = 0; t < w; t++) begin
      if (cmdA[t] != 0) begin
        chkEq(pd ? "R13 only refreshes" : "R8 only refreshes", cmdA[t], 1);
        if (n < 16) begin pos[n] = t; n++; end
      end
    end
    chkEq(pd ? "R13 refresh count" : "R8 refresh count", int'(n >= 2), 1);
    for (int k = 1; k < n; k++)
      chkEq(pd ? "R13 spacing with power-down" : "R8 spacing", pos[k] - pos[k-1],
            pd ? ri + 2 : ri + 1);
    for (int k = 0; k < n; k++) begin
      if (pd) begin
        chkEq("R13 cke high at refresh", int'(ckeA[pos[k]]), 1);
        if (pos[k] > 0) chkEq("R13 cke raised first", int'(ckeA[pos[k] - 1]), 1);
        if (pos[k] + 2 < w) chkEq("R9 cke low when idle", int'(ckeA[pos[k] + 2]), 0);
      end
    end
    if (!pd)
      for (int t = 0; t < w; t++) chkEq("R11 cke stays high", int'(ckeA[t]), 1);
  endtask

  task automatic runAccessPd(input int gap);
    autoPdEn = 1'b1; refInterval = 16'd60000;
    step(gap + 4);
    chkEq("R9 idle cke low", int'(cke), 0);
    accReq = 1'b1;
    step(1);
    chkEq("R10 cke raised", int'(cke), 1);
    chkEq("R10 no grant yet", int'(accGrant), 0);
    step(1);
    chkEq("R10 grant", int'(accGrant), 1);
    for (int h = 0; h < gap; h++) begin
      step(1);
      chkEq("R10 grant held", int'(accGrant), 1);
    end
    accReq = 1'b0; accDone = 1'b1;
    step(1);
    accDone = 1'b0;
    chkEq("R9 grant released", int'(accGrant), 0);
    chkEq("R9 cke low after access", int'(cke), 0);
  endtask

  task automatic runAccessNoPd(input int gap);
    autoPdEn = 1'b0; refInterval = 16'd60000;
    step(gap + 4);
    chkEq("R11 cke high idle", int'(cke), 1);
    accReq = 1'b1;
    step(1);
    chkEq("R11 grant next cycle", int'(accGrant), 1);
    chkEq("R11 cke high in access", int'(cke), 1);
    accReq = 1'b0; accDone = 1'b1;
    step(1);
    accDone = 1'b0;
    chkEq("R11 grant released", int'(accGrant), 0);
    step(3);
    chkEq("R11 cke still high", int'(cke), 1);
  endtask

  initial begin
    step(3);
    chkIdleState("R1 in reset");
    rstN = 1'b1;
    step(1);
    chkIdleState("R1 after reset");
    for (int g = 0; g < 3; g++) runAccessNoPd(g);
    for (int g = 0; g < 4; g++) runAccessPd(g);
    for (int ri = 2; ri <= 7; ri++) begin
      runPeriodic(1'b0, ri);
      runPeriodic(1'b1, ri);
    end
    for (int d = 0; d < 4; d++) begin
      runRecovery(d, 1'b1, 2 + d);
      runRecovery(d, 1'b0, 2 + d);
    end
    runAccessPd(1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule